// File: doc/BRIEF.md
# Slave-Port Ownership Arbiter for a Multi-Master Crossbar

This block controls a single slave port of a crossbar that joins several prioritised bus masters to several slaves. In every cycle it decides who owns the port: one of the masters, or the crossbar itself. It routes the owner's address-phase signals (transfer type, address, control word, lock) onto the port. It also gives every master a ready indication, which stalls a master that requests the port but does not own it.

Ownership changes only on an address-phase boundary, which is any cycle where the slave ready input is high. The lowest-numbered requesting master wins. There are three exceptions to plain priority:
- A master in a locked sequence keeps the port until one cycle after its lock input falls.
- A halt request hands the port to the crossbar.
- When the owning master stops requesting, the port shows one crossbar-owned idle cycle before the next master takes it.

When nothing requests the port, a configuration input selects how it rests. It is either parked on a chosen master, which can then start a transfer with no arbitration delay, or it is held by the crossbar in a low-power idle state.

Top module: `xbar_sport_arb`

## Requirements
- R1: After reset, with no requests, the owner code `s_owner` is 0, `s_trans` is IDLE (2'b00) and every bit of `m_ready` is 1.
- R2: A master requests the port when its `m_sel` bit is 1 and its 2-bit transfer type is not IDLE (2'b00); NONSEQ is 2'b10 and SEQ is 2'b11. At a boundary, the lowest-indexed requester receives the port for the next cycle, and the owner code is then index+1.
- R3: While the owning master keeps requesting, its transfers pass to the port back to back with no idle inserted. If a higher-priority master requests, it takes over at the next boundary, also with no idle cycle.
- R4: In a cycle where the owning master stops requesting and holds no lock, the port is crossbar-owned (owner code 0, IDLE). A master waiting at that boundary owns the port in the next cycle.
- R5: With no requests and `cfg_park_lp` at 0, the port parks on master `cfg_park_idx`. The owner code shows that index+1, and the transfer type is IDLE while that master does not request. A request from the parked master passes to the port in the same cycle, and that master's `m_ready` stays 1.
- R6: With no requests and `cfg_park_lp` at 1, the crossbar owns the port.
- R7: `halt` high at a boundary makes the crossbar own the port from the next cycle. This does not apply while a lock is being retained.
- R8: Whenever the owner code is 0, `s_trans` is IDLE and `s_addr`, `s_ctrl` and `s_lock` are 0.
- R9: A master that owns the port with its lock input high keeps ownership, even against higher-priority requests, until one cycle after the lock falls. During that hold, while it does not request, `s_trans` is IDLE and the owner code, address, control and lock still come from that master.
- R10: A master that requests but does not own the port has its `m_ready` low. The owning master's `m_ready` follows `s_ready`.
- R11: While `s_ready` is low, ownership does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_sel | input | N_MST | Per-master select of this port |
| m_trans | input | 2*N_MST | Per-master transfer type, master i at bits [2i+1:2i] |
| m_lock | input | N_MST | Per-master locked-sequence flag |
| m_addr | input | AW*N_MST | Per-master address, master i at slice i |
| m_ctrl | input | CW*N_MST | Per-master control word, master i at slice i |
| cfg_park_lp | input | 1 | 1: rest in low-power crossbar ownership; 0: park on a master |
| cfg_park_idx | input | 4 | Master to park on when idle |
| halt | input | 1 | Crossbar takes the port at the next boundary |
| s_ready | input | 1 | Slave ready, marks an address-phase boundary |
| s_trans | output | 2 | Transfer type on the port |
| s_addr | output | AW | Address on the port |
| s_ctrl | output | CW | Control word on the port |
| s_lock | output | 1 | Lock flag on the port |
| s_owner | output | 4 | Owner code: 0 crossbar, else master index+1 |
| m_ready | output | N_MST | Per-master ready/stall |

## Verification
The arbiter is driven with several request patterns, and each one separates a different ownership rule:
- A lone master requesting from crossbar ownership shows the single arbitration wait.
- A high-priority owner streaming with a low-priority master waiting separates a direct handover from the one-cycle idle handover.
- A higher-priority request arriving against a lower-priority owner shows that the takeover happens with no idle cycle.
- All three masters requesting while `s_ready` is low shows that ownership is frozen.
- Requests against a parked owner and against low-power rest tell the two resting modes apart.
- A locked owner facing a competing higher-priority request, followed by a lock release, shows the one extra retention cycle.
- A halt pulse against a streaming owner shows the crossbar takeover and the later recovery.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

    localparam int IDX_W = 4;
    localparam logic [1:0] TR_IDLE = 2'b00;

    typedef enum logic [1:0] {
        OWN_XBAR  = 2'd0,
        OWN_GRANT = 2'd1,
        OWN_PARK  = 2'd2
    } own_kind_e;

    typedef struct packed {
        own_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } owner_t;

    localparam owner_t OWNER_RST = '{kind: OWN_XBAR, idx: '0};

    function automatic logic [IDX_W-1:0] owner_code(owner_t o);
        return (o.kind == OWN_XBAR) ? '0 : o.idx + IDX_W'(1);
    endfunction

endpackage

// File: rtl/xbar_arb_prio.sv
module xbar_arb_prio
    import xbar_arb_pkg::*;
#(
    parameter int N_MST = 3
) (
    input  logic [N_MST-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] win
);
    always_comb begin
        any = |req;
        win = '0;
        for (int i = N_MST - 1; i >= 0; i--) begin
            if (req[i]) win = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xbar_arb_owner.sv
module xbar_arb_owner
    import xbar_arb_pkg::*;
#(
    parameter int N_MST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_ready,
    input  logic             halt,
    input  logic             cfg_park_lp,
    input  logic [IDX_W-1:0] cfg_park_idx,
    input  logic [N_MST-1:0] req,
    input  logic [N_MST-1:0] m_lock,
    input  logic             any,
    input  logic [IDX_W-1:0] win,
    output owner_t           own,
    output logic             hold
);
    logic [N_MST-1:0] lock_d;
    logic             own_req;
    logic             keep;
    owner_t           nxt;

    always_comb begin
        hold    = 1'b0;
        own_req = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (own.idx == IDX_W'(i)) begin
                hold    = (own.kind != OWN_XBAR) && (m_lock[i] || lock_d[i]);
                own_req = req[i];
            end
        end
        keep = hold && (own.kind == OWN_GRANT || own_req);
    end

    always_comb begin
        nxt = own;
        if (s_ready) begin
            if (keep) begin
                nxt = '{kind: OWN_GRANT, idx: own.idx};
            end else if (halt) begin
                nxt = OWNER_RST;
            end else if (any) begin
                nxt = '{kind: OWN_GRANT, idx: win};
            end else if (cfg_park_lp || cfg_park_idx >= IDX_W'(N_MST)) begin
                nxt = OWNER_RST;
            end else begin
                nxt = '{kind: OWN_PARK, idx: cfg_park_idx};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own    <= OWNER_RST;
            lock_d <= '0;
        end else begin
            own    <= nxt;
            lock_d <= m_lock;
        end
    end
endmodule

// File: rtl/xbar_arb_mux.sv
module xbar_arb_mux
    import xbar_arb_pkg::*;
#(
    parameter int N_MST = 3,
    parameter int AW    = 32,
    parameter int CW    = 8
) (
    input  owner_t              own,
    input  logic                hold,
    input  logic                s_ready,
    input  logic [N_MST-1:0]    req,
    input  logic [N_MST-1:0]    m_lock,
    input  logic [2*N_MST-1:0]  m_trans,
    input  logic [AW*N_MST-1:0] m_addr,
    input  logic [CW*N_MST-1:0] m_ctrl,
    output logic [1:0]          s_trans,
    output logic [AW-1:0]       s_addr,
    output logic [CW-1:0]       s_ctrl,
    output logic                s_lock,
    output logic [IDX_W-1:0]    s_owner,
    output logic [N_MST-1:0]    m_ready
);
    logic [1:0]    sel_trans;
    logic [AW-1:0] sel_addr;
    logic [CW-1:0] sel_ctrl;
    logic          sel_lock;
    logic          sel_req;
    logic          xview;

    always_comb begin
        sel_trans = TR_IDLE;
        sel_addr  = '0;
        sel_ctrl  = '0;
        sel_lock  = 1'b0;
        sel_req   = 1'b0;
        for (int i = 0; i < N_MST; i++) begin
            if (own.idx == IDX_W'(i)) begin
                sel_trans = m_trans[2*i +: 2];
                sel_addr  = m_addr[AW*i +: AW];
                sel_ctrl  = m_ctrl[CW*i +: CW];
                sel_lock  = m_lock[i];
                sel_req   = req[i];
            end
        end
        xview = (own.kind == OWN_XBAR) ||
                (own.kind == OWN_GRANT && !sel_req && !hold);
        if (xview) begin
            s_trans = TR_IDLE;
            s_addr  = '0;
            s_ctrl  = '0;
            s_lock  = 1'b0;
            s_owner = '0;
        end else begin
            s_trans = sel_req ? sel_trans : TR_IDLE;
            s_addr  = sel_addr;
            s_ctrl  = sel_ctrl;
            s_lock  = sel_lock && (own.kind == OWN_GRANT || sel_req);
            s_owner = owner_code(own);
        end
    end

    for (genvar i = 0; i < N_MST; i++) begin : g_rdy
        assign m_ready[i] = (own.kind != OWN_XBAR && own.idx == IDX_W'(i))
                            ? s_ready : !req[i];
    end
endmodule

// File: rtl/xbar_sport_arb.sv
module xbar_sport_arb
    import xbar_arb_pkg::*;
#(
    parameter int N_MST = 3,
    parameter int AW    = 32,
    parameter int CW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_MST-1:0]    m_sel,
    input  logic [2*N_MST-1:0]  m_trans,
    input  logic [N_MST-1:0]    m_lock,
    input  logic [AW*N_MST-1:0] m_addr,
    input  logic [CW*N_MST-1:0] m_ctrl,
    input  logic                cfg_park_lp,
    input  logic [3:0]          cfg_park_idx,
    input  logic                halt,
    input  logic                s_ready,
    output logic [1:0]          s_trans,
    output logic [AW-1:0]       s_addr,
    output logic [CW-1:0]       s_ctrl,
    output logic                s_lock,
    output logic [3:0]          s_owner,
    output logic [N_MST-1:0]    m_ready
);
    logic [N_MST-1:0] req;
    logic             any;
    logic [IDX_W-1:0] win;
    owner_t           own;
    logic             hold;

    for (genvar i = 0; i < N_MST; i++) begin : g_req
        assign req[i] = m_sel[i] && (m_trans[2*i +: 2] != TR_IDLE);
    end

    xbar_arb_prio #(.N_MST(N_MST)) prio_i (
        .req (req),
        .any (any),
        .win (win)
    );

    xbar_arb_owner #(.N_MST(N_MST)) owner_i (
        .clk          (clk),
        .rst          (rst),
        .s_ready      (s_ready),
        .halt         (halt),
        .cfg_park_lp  (cfg_park_lp),
        .cfg_park_idx (cfg_park_idx),
        .req          (req),
        .m_lock       (m_lock),
        .any          (any),
        .win          (win),
        .own          (own),
        .hold         (hold)
    );

    xbar_arb_mux #(.N_MST(N_MST), .AW(AW), .CW(CW)) mux_i (
        .own     (own),
        .hold    (hold),
        .s_ready (s_ready),
        .req     (req),
        .m_lock  (m_lock),
        .m_trans (m_trans),
        .m_addr  (m_addr),
        .m_ctrl  (m_ctrl),
        .s_trans (s_trans),
        .s_addr  (s_addr),
        .s_ctrl  (s_ctrl),
        .s_lock  (s_lock),
        .s_owner (s_owner),
        .m_ready (m_ready)
    );
endmodule

// File: rtl/xbar_sport_arb_chk.sv
module xbar_sport_arb_chk #(
    parameter int N_MST = 3,
    parameter int AW    = 32,
    parameter int CW    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [N_MST-1:0]    m_sel,
    input logic [2*N_MST-1:0]  m_trans,
    input logic [N_MST-1:0]    m_lock,
    input logic                halt,
    input logic                s_ready,
    input logic [1:0]          s_trans,
    input logic [AW-1:0]       s_addr,
    input logic [CW-1:0]       s_ctrl,
    input logic                s_lock,
    input logic [3:0]          s_owner,
    input logic [N_MST-1:0]    m_ready
);
    logic [N_MST-1:0] req_v;
    logic [1:0]       cyc;

    for (genvar i = 0; i < N_MST; i++) begin : g_rq
        assign req_v[i] = m_sel[i] && (m_trans[2*i +: 2] != 2'b00);
    end

    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    AST_XBAR_IDLE_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (s_owner == 4'd0) |-> (s_trans == 2'b00 && s_addr == '0 && s_ctrl == '0 && !s_lock)); // R8

    AST_SINGLE_READY_REQ: assert property (@(posedge clk) disable iff (rst)
        $countones(req_v & m_ready) <= 1); // R10

    AST_TOP_PRIO_NEXT: assert property (@(posedge clk) disable iff (rst)
        (s_owner == 4'd0 && s_ready && !halt && req_v[0]) |=> (!req_v[0] || s_owner == 4'd1)); // R2

    AST_LOCK_RETAINED: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(s_lock) && $past(s_ready)) |-> (s_owner == $past(s_owner))); // R9

    AST_HALT_TAKES_PORT: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(halt) && $past(s_ready) && $past(m_lock) == '0 && $past(m_lock, 2) == '0)
        |-> (s_owner == 4'd0)); // R7

    for (genvar i = 0; i < N_MST; i++) begin : g_mr
        AST_STALL_NON_OWNER: assert property (@(posedge clk) disable iff (rst)
            (req_v[i] && s_owner != 4'(i + 1)) |-> !m_ready[i]); // R10

        AST_OWNER_READY: assert property (@(posedge clk) disable iff (rst)
            (req_v[i] && s_owner == 4'(i + 1)) |-> (m_ready[i] == s_ready)); // R10
    end
endmodule

bind xbar_sport_arb xbar_sport_arb_chk #(.N_MST(N_MST), .AW(AW), .CW(CW)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .m_sel   (m_sel),
    .m_trans (m_trans),
    .m_lock  (m_lock),
    .halt    (halt),
    .s_ready (s_ready),
    .s_trans (s_trans),
    .s_addr  (s_addr),
    .s_ctrl  (s_ctrl),
    .s_lock  (s_lock),
    .s_owner (s_owner),
    .m_ready (m_ready)
);

// File: tb/xbar_sport_arb_tb_top.sv
module xbar_sport_arb_tb_top;
    localparam int N  = 3;
    localparam int AW = 16;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    m_sel = '0;
    logic [2*N-1:0]  m_trans = '0;
    logic [N-1:0]    m_lock = '0;
    logic [AW*N-1:0] m_addr;
    logic [CW*N-1:0] m_ctrl;
    logic            cfg_park_lp = 1'b1;
    logic [3:0]      cfg_park_idx = 4'd0;
    logic            halt = 1'b0;
    logic            s_ready = 1'b1;
    logic [1:0]      s_trans;
    logic [AW-1:0]   s_addr;
    logic [CW-1:0]   s_ctrl;
    logic            s_lock;
    logic [3:0]      s_owner;
    logic [N-1:0]    m_ready;

    typedef struct {
        logic [3:0] own;
        logic [1:0] tr;
        logic [2:0] rdy;
        string      tag;
    } exp_item_t;

    exp_item_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_src
        assign m_addr[AW*i +: AW] = AW'((i + 1) << 12);
        assign m_ctrl[CW*i +: CW] = CW'(i + 1);
    end

    xbar_sport_arb #(.N_MST(N), .AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .m_sel(m_sel), .m_trans(m_trans), .m_lock(m_lock),
        .m_addr(m_addr), .m_ctrl(m_ctrl), .cfg_park_lp(cfg_park_lp),
        .cfg_park_idx(cfg_park_idx), .halt(halt), .s_ready(s_ready),
        .s_trans(s_trans), .s_addr(s_addr), .s_ctrl(s_ctrl), .s_lock(s_lock),
        .s_owner(s_owner), .m_ready(m_ready)
    );

    task automatic drive(input logic [2:0] sel, input logic [1:0] t, input logic [2:0] lk,
                         input logic hl, input logic rdy, input logic lp, input logic [3:0] pidx,
                         input logic [3:0] e_own, input logic [1:0] e_tr, input logic [2:0] e_rdy,
                         input string tag);
        exp_item_t it;
        @(negedge clk);
        m_sel = sel;
        for (int i = 0; i < N; i++) m_trans[2*i +: 2] = sel[i] ? t : 2'b00;
        m_lock = lk;
        halt = hl;
        s_ready = rdy;
        cfg_park_lp = lp;
        cfg_park_idx = pidx;
        it.own = e_own;
        it.tr = e_tr;
        it.rdy = e_rdy;
        it.tag = tag;
        q.push_back(it);
    endtask

    initial begin : monitor
        exp_item_t it;
        logic [AW-1:0] ea;
        forever begin
            @(negedge clk);
            #8;
            if (q.size() > 0) begin
                it = q.pop_front();
                ea = {it.own, 12'h000};
                total++;
                if (s_owner !== it.own || s_trans !== it.tr || m_ready !== it.rdy ||
                    s_addr !== ea || s_ctrl !== it.own) begin
                    bad++;
                    $display("FAIL %s: own=%0d tr=%b rdy=%b addr=%h ctrl=%h expected own=%0d tr=%b rdy=%b addr=%h ctrl=%h",
                             it.tag, s_owner, s_trans, m_ready, s_addr, s_ctrl,
                             it.own, it.tr, it.rdy, ea, it.own);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        //    sel     t      lock   hl rdy lp pidx  own   tr     rdy
        drive(3'b000, 2'b00, 3'b000, 0, 1, 1, 4'd0, 4'd0, 2'b00, 3'b111, "R1 reset state");
        drive(3'b001, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd0, 2'b00, 3'b110, "R10 stall before grant");
        drive(3'b101, 2'b11, 3'b000, 0, 1, 1, 4'd0, 4'd1, 2'b11, 3'b011, "R2 lowest index granted");
        drive(3'b101, 2'b11, 3'b000, 0, 1, 1, 4'd0, 4'd1, 2'b11, 3'b011, "R3 back to back");
        drive(3'b100, 2'b11, 3'b000, 0, 1, 1, 4'd0, 4'd0, 2'b00, 3'b011, "R4 handover idle");
        drive(3'b100, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd3, 2'b10, 3'b111, "R4 waiter owns next");
        drive(3'b110, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd3, 2'b10, 3'b101, "R10 higher waits");
        drive(3'b110, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd2, 2'b10, 3'b011, "R3 takeover no idle");
        drive(3'b111, 2'b10, 3'b000, 0, 0, 1, 4'd0, 4'd2, 2'b10, 3'b000, "R11 ready low");
        drive(3'b111, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd2, 2'b10, 3'b010, "R11 owner kept");
        drive(3'b000, 2'b00, 3'b000, 0, 1, 0, 4'd2, 4'd0, 2'b00, 3'b111, "R8 owner leaves");
        drive(3'b000, 2'b00, 3'b000, 0, 1, 0, 4'd2, 4'd3, 2'b00, 3'b111, "R5 parked on master");
        drive(3'b100, 2'b10, 3'b000, 0, 1, 0, 4'd2, 4'd3, 2'b10, 3'b111, "R5 parked passes");
        drive(3'b000, 2'b00, 3'b000, 0, 1, 1, 4'd2, 4'd0, 2'b00, 3'b111, "R8 idle pattern");
        drive(3'b000, 2'b00, 3'b000, 0, 1, 1, 4'd2, 4'd0, 2'b00, 3'b111, "R6 low power park");
        drive(3'b010, 2'b10, 3'b010, 0, 1, 1, 4'd0, 4'd0, 2'b00, 3'b101, "R9 lock request");
        drive(3'b011, 2'b11, 3'b010, 0, 1, 1, 4'd0, 4'd2, 2'b11, 3'b110, "R9 lock beats priority");
        drive(3'b001, 2'b10, 3'b010, 0, 1, 1, 4'd0, 4'd2, 2'b00, 3'b110, "R9 lock hold idle");
        drive(3'b001, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd2, 2'b00, 3'b110, "R9 one cycle tail");
        drive(3'b001, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd0, 2'b00, 3'b110, "R9 released");
        drive(3'b001, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd1, 2'b10, 3'b111, "R2 waiter granted");
        drive(3'b001, 2'b10, 3'b000, 1, 1, 1, 4'd0, 4'd1, 2'b10, 3'b111, "R7 halt at boundary");
        drive(3'b001, 2'b10, 3'b000, 1, 1, 1, 4'd0, 4'd0, 2'b00, 3'b110, "R7 crossbar owns");
        drive(3'b001, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd0, 2'b00, 3'b110, "R7 halt released");
        drive(3'b001, 2'b10, 3'b000, 0, 1, 1, 4'd0, 4'd1, 2'b10, 3'b111, "R2 regrant after halt");
        @(negedge clk);
        #12;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule